// File: doc/BRIEF.md
# Parallel NOR Flash Write Sequencer

This block sits on the host side of an 8-bit parallel NOR flash device and carries out one write-class operation per request. It can program a single byte or erase the whole chip. A request arrives on a valid/ready handshake. The block then emits the unlock and command writes for that operation on the flash bus, using chip-enable, write-enable and output-enable strobes. The setup, pulse and hold phases of each bus cycle last a fixed number of clock cycles, each set by a parameter.

After the last command write has finished, the block reads the target location over and over. It watches bit 6 of the returned byte. While the device is working, that bit flips on every read. Once two reads in a row agree on bit 6, the block reads the same location twice more to confirm the result. The confirming reads must return the requested byte after a program, or FFh after an erase. The outcome is reported by a one-cycle done pulse with an error flag. A cycle counter limits how long polling may last.

The request side applies back-pressure by holding `req_ready` low for the whole operation. A request is taken only in a cycle where `req_valid` and `req_ready` are both high. An offered request may wait any number of cycles. Result reporting is a plain pulse with no back-pressure.

Top module: `nor_wr_ctrl`

## Requirements
- R1: After reset `busy_o` is 0, `req_ready` is 1 and all three flash strobes are high. A request is accepted in a cycle with `req_valid` and `req_ready` both high, and `busy_o` is 1 from the next cycle. While `busy_o` is 1, `req_ready` is 0 and an offered request produces no bus activity.
- R2: A request with `req_op`=0 (program) issues exactly four writes, each as (address, data): (5555h, AAh), (2AAAh, 55h), (5555h, A0h), (`req_addr`, `req_data`).
- R3: A request with `req_op`=1 (chip erase) issues exactly six writes: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), (5555h, 10h).
- R4: In every write cycle, chip-enable goes low T_SU clocks before write-enable falls. Write-enable then stays low for T_PW clocks, and chip-enable stays low for T_HD clocks after write-enable rises. Output-enable stays high throughout. Address and write data do not change while write-enable is low.
- R5: No read strobe (output-enable low) occurs until the rising edge of the last command write has passed. Each read holds output-enable low for T_PW clocks, with write-enable high.
- R6: Polling reads the operation address and continues while bit 6 differs between successive reads. It stops on the first read whose bit 6 equals that of the previous read.
- R7: Polling is followed by exactly two confirming reads of the same address. If both return the expected value (`req_data` for a program, FFh for an erase), the block reports done with `err_o`=0.
- R8: If either confirming read differs from the expected value, the block reports done with `err_o`=1.
- R9: If polling has lasted TMO_CYC clocks, the block stops after the read in progress, skips the confirming reads and reports done with `err_o`=1.
- R10: `done_o` is high for exactly one cycle, which is also the first cycle with `busy_o` at 0. `err_o` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 1 | 0 = byte program, 1 = chip erase |
| req_addr | input | AW | Target byte address (also the poll address for erase) |
| req_data | input | 8 | Byte to program |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Operation failed; valid with done_o |
| fl_addr | output | AW | Flash address bus |
| fl_dq_o | output | 8 | Flash data bus, write direction |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_o |
| fl_dq_i | input | 8 | Flash data bus, read direction |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |

## Verification
A wrong step index or operation type shows as a wrong address or data byte at the first affected write-enable rising edge. The scoreboard compares every write against its expected item, so such a fault is caught within one bus cycle of its cause. A fault in the poll or confirm logic shows as a wrong count of read strobes before `done_o`, or as a wrong `err_o`. The bench derives that count from the number of toggling reads the flash model returns, so a miscount is detected at the done pulse. A phase counter that is off by one shows as a wrong strobe width, which is measured in clock cycles on the first write.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  typedef enum logic {OP_PROG = 1'b0, OP_ERASE = 1'b1} op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_POLL, ST_CHK} st_e;
  typedef enum logic [1:0] {PH_IDLE, PH_SU, PH_PW, PH_HD} ph_e;

  localparam int STEP_W = 3;
  localparam logic [15:0] UNLK_LO = 16'h5555;
  localparam logic [15:0] UNLK_HI = 16'h2AAA;
  localparam logic [7:0]  KEY_1   = 8'hAA;
  localparam logic [7:0]  KEY_2   = 8'h55;
  localparam logic [7:0]  OPC_PGM = 8'hA0;
  localparam logic [7:0]  OPC_ERS = 8'h80;
  localparam logic [7:0]  OPC_ALL = 8'h10;
  localparam logic [7:0]  BLANK   = 8'hFF;
endpackage

// File: rtl/nfc_cmd_rom.sv
module nfc_cmd_rom
  import nfc_pkg::*;
#(
  parameter int AW = 19
) (
  input  op_e               op_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [AW-1:0]     tgt_addr_i,
  input  logic [7:0]        tgt_data_i,
  output logic [AW-1:0]     wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              last_o
);
  localparam logic [AW-1:0] A_LO = AW'(UNLK_LO);
  localparam logic [AW-1:0] A_HI = AW'(UNLK_HI);
  localparam logic [STEP_W-1:0] PGM_LAST = STEP_W'(3);
  localparam logic [STEP_W-1:0] ERS_LAST = STEP_W'(5);

  always_comb begin
    wr_addr_o = A_LO;
    wr_data_o = KEY_1;
    unique case (step_i)
      STEP_W'(0): begin wr_addr_o = A_LO; wr_data_o = KEY_1; end
      STEP_W'(1): begin wr_addr_o = A_HI; wr_data_o = KEY_2; end
      STEP_W'(2): begin
        wr_addr_o = A_LO;
        wr_data_o = (op_i == OP_PROG) ? OPC_PGM : OPC_ERS;
      end
      STEP_W'(3): begin
        wr_addr_o = (op_i == OP_PROG) ? tgt_addr_i : A_LO;
        wr_data_o = (op_i == OP_PROG) ? tgt_data_i : KEY_1;
      end
      STEP_W'(4): begin wr_addr_o = A_HI; wr_data_o = KEY_2; end
      default:    begin wr_addr_o = A_LO; wr_data_o = OPC_ALL; end
    endcase
    last_o = (op_i == OP_PROG) ? (step_i == PGM_LAST) : (step_i == ERS_LAST);
  end
endmodule

// File: rtl/nfc_bus_cycle.sv
module nfc_bus_cycle
  import nfc_pkg::*;
#(
  parameter int AW   = 19,
  parameter int T_SU = 2,
  parameter int T_PW = 3,
  parameter int T_HD = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic          done_o,
  output logic [7:0]    rdata_o,
  input  logic [7:0]    fl_dq_i,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    dq_o,
  output logic          dq_oe_o,
  output logic          ce_n_o,
  output logic          we_n_o,
  output logic          oe_n_o
);
  localparam int TMAX = (T_SU > T_PW) ? ((T_SU > T_HD) ? T_SU : T_HD)
                                      : ((T_PW > T_HD) ? T_PW : T_HD);
  localparam int CW = $clog2(TMAX + 1);
  localparam logic [CW-1:0] SU_LD = CW'(T_SU - 1);
  localparam logic [CW-1:0] PW_LD = CW'(T_PW - 1);
  localparam logic [CW-1:0] HD_LD = CW'(T_HD - 1);

  ph_e           ph;
  logic [CW-1:0] cnt;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    dat_q;
  logic [7:0]    rd_q;
  logic          last_tick;

  assign last_tick = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      dat_q  <= '0;
      rd_q   <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: if (start_i) begin
          ph     <= PH_SU;
          cnt    <= SU_LD;
          wr_q   <= wr_i;
          addr_q <= addr_i;
          dat_q  <= wdata_i;
        end
        PH_SU: if (last_tick) begin
          ph  <= PH_PW;
          cnt <= PW_LD;
        end else cnt <= cnt - 1'b1;
        PH_PW: if (last_tick) begin
          ph  <= PH_HD;
          cnt <= HD_LD;
          if (!wr_q) rd_q <= fl_dq_i;
        end else cnt <= cnt - 1'b1;
        default: if (last_tick) ph <= PH_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign done_o  = (ph == PH_HD) && last_tick;
  assign rdata_o = rd_q;
  assign addr_o  = addr_q;
  assign dq_o    = dat_q;
  assign dq_oe_o = wr_q && (ph != PH_IDLE);
  assign ce_n_o  = (ph == PH_IDLE);
  assign we_n_o  = !((ph == PH_PW) && wr_q);
  assign oe_n_o  = !((ph == PH_PW) && !wr_q);

  // R4: address and data held for the whole write pulse
  p_pulse_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n_o && $past(!we_n_o)) |-> ($stable(addr_o) && $stable(dq_o)));
  // R4: chip enable still low on the edge where write enable rises
  p_ce_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n_o) |-> !ce_n_o);
  // R5: a new cycle is only requested while the engine is idle
  p_start_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> ce_n_o);
endmodule

// File: rtl/nfc_tmo.sv
module nfc_tmo #(
  parameter int LIMIT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run_i)     cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign expired_o = (cnt == LIM);

  // R9: expiry only ever follows a cycle spent polling
  p_expire_after_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    expired_o |-> $past(run_i));
endmodule

// File: rtl/nor_wr_ctrl.sv
module nor_wr_ctrl
  import nfc_pkg::*;
#(
  parameter int AW      = 19,
  parameter int T_SU    = 2,
  parameter int T_PW    = 3,
  parameter int T_HD    = 1,
  parameter int TMO_CYC = 100000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_o,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_i,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);
  st_e               st;
  op_e               op_q;
  logic [AW-1:0]     addr_q;
  logic [7:0]        data_q;
  logic [STEP_W-1:0] step;
  logic              issued;
  logic              first_rd;
  logic              prev6;
  logic              conf_2nd;
  logic              conf_bad;

  logic [AW-1:0] rom_addr;
  logic [7:0]    rom_data;
  logic          rom_last;
  logic          bus_start;
  logic          bus_done;
  logic [7:0]    bus_rdata;
  logic          tmo_hit;
  logic [7:0]    expect_val;
  logic          rd_miss;

  nfc_cmd_rom #(.AW(AW)) u_rom (
    .op_i(op_q), .step_i(step), .tgt_addr_i(addr_q), .tgt_data_i(data_q),
    .wr_addr_o(rom_addr), .wr_data_o(rom_data), .last_o(rom_last)
  );

  nfc_bus_cycle #(.AW(AW), .T_SU(T_SU), .T_PW(T_PW), .T_HD(T_HD)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .start_i(bus_start), .wr_i(st == ST_CMD),
    .addr_i((st == ST_CMD) ? rom_addr : addr_q), .wdata_i(rom_data),
    .done_o(bus_done), .rdata_o(bus_rdata), .fl_dq_i(fl_dq_i),
    .addr_o(fl_addr), .dq_o(fl_dq_o), .dq_oe_o(fl_dq_oe),
    .ce_n_o(fl_ce_n), .we_n_o(fl_we_n), .oe_n_o(fl_oe_n)
  );

  nfc_tmo #(.LIMIT(TMO_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n), .run_i(st == ST_POLL), .expired_o(tmo_hit)
  );

  assign busy_o     = (st != ST_IDLE);
  assign req_ready  = !busy_o;
  assign bus_start  = busy_o && !issued;
  assign expect_val = (op_q == OP_ERASE) ? BLANK : data_q;
  assign rd_miss    = (bus_rdata != expect_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      op_q     <= OP_PROG;
      addr_q   <= '0;
      data_q   <= '0;
      step     <= '0;
      issued   <= 1'b0;
      first_rd <= 1'b0;
      prev6    <= 1'b0;
      conf_2nd <= 1'b0;
      conf_bad <= 1'b0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (st == ST_IDLE) begin
        if (req_valid) begin
          st     <= ST_CMD;
          op_q   <= op_e'(req_op);
          addr_q <= req_addr;
          data_q <= req_data;
          step   <= '0;
          issued <= 1'b0;
        end
      end else if (bus_start) begin
        issued <= 1'b1;
      end else if (bus_done) begin
        issued <= 1'b0;
        unique case (st)
          ST_CMD: if (rom_last) begin
            st       <= ST_POLL;
            first_rd <= 1'b1;
          end else step <= step + 1'b1;
          ST_POLL: if (tmo_hit) begin
            st     <= ST_IDLE;
            done_o <= 1'b1;
            err_o  <= 1'b1;
          end else if (first_rd) begin
            first_rd <= 1'b0;
            prev6    <= bus_rdata[6];
          end else if (bus_rdata[6] == prev6) begin
            st       <= ST_CHK;
            conf_2nd <= 1'b0;
            conf_bad <= 1'b0;
          end else prev6 <= bus_rdata[6];
          default: if (conf_2nd) begin
            st     <= ST_IDLE;
            done_o <= 1'b1;
            err_o  <= conf_bad | rd_miss;
          end else begin
            conf_2nd <= 1'b1;
            conf_bad <= rd_miss;
          end
        endcase
      end
    end
  end

  // R1: an accepted request makes the block busy on the next cycle
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy_o);
  // R5: no read strobe while command writes are still being issued
  p_no_read_in_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CMD) |-> fl_oe_n);
  // R10: completion pulse lasts one cycle
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R10: completion coincides with the idle state
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R9: timeout abort always carries the error flag
  p_tmo_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(tmo_hit)) |-> err_o);
endmodule

// File: tb/sim_nor_wr_ctrl.sv
module sim_nor_wr_ctrl;
  localparam int AW = 19, T_SU = 2, T_PW = 3, T_HD = 1, TMO = 800;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_op = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_data = '0, fl_dq_i = 8'hFF, fl_dq_o;
  logic req_ready, busy_o, done_o, err_o, fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;
  logic [AW-1:0] fl_addr;

  always #5 clk = ~clk;

  nor_wr_ctrl #(.AW(AW), .T_SU(T_SU), .T_PW(T_PW), .T_HD(T_HD), .TMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  int total = 0, bad = 0, cyc = 0, done_seen = 0, last_wr_cyc = 0, done_cyc = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard queues
  logic [AW-1:0] ea[$];
  logic [7:0]    ed[$];
  string         etag[$];
  bit            er[$];

  // flash model
  logic [7:0] mem[int];
  logic [AW-1:0] wa[$];
  logic [7:0] wd[$];
  int busy_left = 0, cfg_b = 0, rd_cnt = 0, data_rds = 0;
  bit tog = 0, cor = 0;
  logic [AW-1:0] cor_addr = '0;

  always @(posedge fl_we_n) if (!fl_ce_n) begin
    if (ea.size() == 0) chk(0, "R1/R2/R3 unexpected write", fl_addr, 0);
    else begin
      automatic logic [AW-1:0] xa = ea.pop_front();
      automatic logic [7:0] xd = ed.pop_front();
      automatic string t = etag.pop_front();
      chk(fl_addr == xa, {t, " addr"}, fl_addr, xa);
      chk(fl_dq_o == xd, {t, " data"}, fl_dq_o, xd);
      chk(fl_oe_n == 1'b1 && fl_dq_oe, "R4 oe high, data driven", fl_oe_n, 1);
      if (ea.size() == 0) last_wr_cyc = cyc;
    end
    wa.push_back(fl_addr);
    wd.push_back(fl_dq_o);
    if (wa.size() >= 4 && wd[wa.size()-2] == 8'hA0) begin
      mem[int'(fl_addr)] = cor ? (fl_dq_o ^ 8'h01) : fl_dq_o;
      busy_left = cfg_b; tog = 0; wa.delete(); wd.delete();
    end else if (wa.size() >= 6 && wd[wa.size()-1] == 8'h10 && wd[wa.size()-4] == 8'h80) begin
      mem.delete();
      if (cor) mem[int'(cor_addr)] = 8'h7E;
      busy_left = cfg_b; tog = 0; wa.delete(); wd.delete();
    end
  end

  always @(negedge fl_oe_n) begin
    chk(ea.size() == 0 && fl_we_n, "R5 read only after last write", ea.size(), 0);
    rd_cnt++;
    if (busy_left > 0) begin
      busy_left--; tog = ~tog;
      fl_dq_i = {1'b0, tog, 6'h15};
    end else begin
      data_rds++;
      fl_dq_i = mem.exists(int'(fl_addr)) ? mem[int'(fl_addr)] : 8'hFF;
    end
  end

  // result monitor
  bit prev_done = 0;
  always @(negedge clk) begin
    if (prev_done) chk(!done_o, "R10 done one cycle", done_o, 0);
    if (done_o) begin
      chk(!busy_o && req_ready, "R10 idle with done", busy_o, 0);
      if (er.size() == 0) chk(0, "R10 unexpected done", 1, 0);
      else begin
        automatic bit x = er.pop_front();
        chk(err_o == x, "R7/R8/R9 err flag", err_o, x);
      end
      done_cyc = cyc;
      done_seen++;
    end
    prev_done = done_o;
  end

  task automatic push_w(input logic [AW-1:0] a, input logic [7:0] d, input string t);
    ea.push_back(a); ed.push_back(d); etag.push_back(t);
  endtask

  task automatic do_op(input bit op, input logic [AW-1:0] a, input logic [7:0] d,
                       input int b, input bit corrupt, input bit xerr, input bit poke);
    int n0;
    cor = corrupt; cor_addr = a; cfg_b = b; rd_cnt = 0; data_rds = 0;
    push_w(19'h5555, 8'hAA, op ? "R3" : "R2");
    push_w(19'h2AAA, 8'h55, op ? "R3" : "R2");
    if (!op) begin
      push_w(19'h5555, 8'hA0, "R2");
      push_w(a, d, "R2");
    end else begin
      push_w(19'h5555, 8'h80, "R3");
      push_w(19'h5555, 8'hAA, "R3");
      push_w(19'h2AAA, 8'h55, "R3");
      push_w(19'h5555, 8'h10, "R3");
    end
    er.push_back(xerr);
    n0 = done_seen;
    @(negedge clk);
    chk(req_ready, "R1 ready when idle", req_ready, 1);
    req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy_o && !req_ready, "R1 busy after accept", busy_o, 1);
    if (poke) begin
      req_valid = 1'b1; req_op = ~op; req_addr = '1;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk(!req_ready, "R1 ready low while busy", req_ready, 0);
      end
      req_valid = 1'b0;
    end
    while (done_seen == n0) @(negedge clk);
    chk(ea.size() == 0, "R2/R3 all writes issued", ea.size(), 0);
  endtask

  // expected read count: toggling reads, stop on first equal pair, two confirms
  function automatic int exp_reads(input int b, input logic [7:0] stored);
    int stop;
    if (b == 0) stop = 2;
    else stop = ((b % 2 == 1) == stored[6]) ? b + 1 : b + 2;
    return stop + 2;
  endfunction

  task automatic measure_write();
    int n;
    @(negedge clk);
    while (fl_ce_n) @(negedge clk);
    n = 0; while (fl_we_n) begin n++; @(negedge clk); end
    chk(n == T_SU, "R4 setup clocks", n, T_SU);
    n = 0; while (!fl_we_n) begin n++; @(negedge clk); end
    chk(n == T_PW, "R4 pulse clocks", n, T_PW);
    n = 0; while (!fl_ce_n) begin n++; @(negedge clk); end
    chk(n == T_HD, "R4 hold clocks", n, T_HD);
  endtask

  task automatic measure_read();
    int n;
    while (fl_oe_n) @(negedge clk);
    n = 0; while (!fl_oe_n) begin chk(fl_we_n, "R5 we high in read", fl_we_n, 1); n++; @(negedge clk); end
    chk(n == T_PW, "R5 read strobe clocks", n, T_PW);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && req_ready, "R1 reset idle", busy_o, 0);
    chk(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe, "R1 reset strobes high",
        {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o, "R1 idle without request", busy_o, 0);

    fork
      measure_write();
      do_op(1'b0, 19'h01234, 8'h5A, 3, 1'b0, 1'b0, 1'b0);
    join
    chk(rd_cnt == exp_reads(3, 8'h5A), "R6/R7 program read count", rd_cnt, exp_reads(3, 8'h5A));

    fork
      measure_read();
      do_op(1'b0, 19'h7FFFF, 8'h3C, 4, 1'b0, 1'b0, 1'b1);
    join
    chk(rd_cnt == exp_reads(4, 8'h3C), "R6/R7 toggled-even read count", rd_cnt, exp_reads(4, 8'h3C));

    do_op(1'b0, 19'h00010, 8'hC3, 0, 1'b0, 1'b0, 1'b0);
    chk(rd_cnt == exp_reads(0, 8'hC3), "R6 no toggling read count", rd_cnt, exp_reads(0, 8'hC3));

    do_op(1'b1, 19'h04000, 8'h00, 5, 1'b0, 1'b0, 1'b0);
    chk(rd_cnt == exp_reads(5, 8'hFF), "R3/R7 erase read count", rd_cnt, exp_reads(5, 8'hFF));

    do_op(1'b0, 19'h00222, 8'h81, 2, 1'b1, 1'b1, 1'b0);
    chk(rd_cnt == exp_reads(2, 8'h80), "R8 program mismatch reads", rd_cnt, exp_reads(2, 8'h80));

    do_op(1'b1, 19'h00333, 8'h00, 1, 1'b1, 1'b1, 1'b0);
    chk(rd_cnt == exp_reads(1, 8'h7E), "R8 erase mismatch reads", rd_cnt, exp_reads(1, 8'h7E));

    do_op(1'b0, 19'h00444, 8'h11, 1000000, 1'b0, 1'b1, 1'b0);
    chk(data_rds == 0, "R9 no confirm reads after timeout", data_rds, 0);
    chk(done_cyc - last_wr_cyc >= TMO, "R9 polled for timeout window", done_cyc - last_wr_cyc, TMO);
    busy_left = 0;

    do_op(1'b0, 19'h00555, 8'h77, 2, 1'b0, 1'b0, 1'b0);
    chk(rd_cnt == exp_reads(2, 8'h77), "R9 recovers after timeout", rd_cnt, exp_reads(2, 8'h77));

    repeat (5) @(negedge clk);
    chk(er.size() == 0 && ea.size() == 0, "R10 no pending results", er.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule